// File: doc/BRIEF.md
# Slow-Idle Clock-Enable Controller

This block sits beside a processor core. It decides in which cycles the core may run and in which cycles the slower derived clocks (serial clock, clock output, timer) may advance. The core issues an idle command in one cycle and qualifies it with a standard-idle bit and a 2-bit divisor code. The command stops instruction execution. In standard idle the derived-clock enable stays on every cycle. In divided idle it fires once every n cycles, where n is 16, 32, 64 or 128.

The block leaves idle only when an unmasked interrupt is pending. In standard idle the core restarts on the next cycle. In divided idle the block first lets the current slowed period run to its end, so the exit costs up to n cycles. A one-cycle resume strobe marks the first running cycle, so the core can service the interrupt and then continue after the idle command.

DMA and autobuffer requests are granted in every state, idle or running. At most one grant is given per cycle, and the lowest-numbered request wins.

Top module: `slow_idle_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `core_ce` and `aux_ce` are 1, `resume_pulse` is 0 and `dma_grant` is all zeros.
- R2: While running, `core_ce` and `aux_ce` are both 1 every cycle. An `idle_req` sampled high while running makes `core_ce` 0 from the next cycle on.
- R3: In standard idle (`idle_full`=1 at entry), `aux_ce` is 1 every cycle. An `irq_pending` sampled high makes `core_ce` 1 on the next cycle.
- R4: The divisor code is `idle_div_sel` 00=16, 01=32, 10=64, 11=128. In divided idle the period counter restarts at entry. Counting the first idle cycle as cycle 0, `aux_ce` is 1 only in cycles n-1, 2n-1, and so on.
- R5: In divided idle, a pending interrupt takes effect only in a cycle where `aux_ce` is 1. `core_ce` returns the cycle after that. An interrupt raised in cycle k (0 ≤ k < n) of a period therefore resumes at cycle n.
- R6: `resume_pulse` is high for exactly one cycle, the first cycle in which `core_ce` is 1 again after idle.
- R7: `irq_pending` while running has no effect: `core_ce` stays 1 and `resume_pulse` stays 0.
- R8: `dma_grant` is registered one cycle after `dma_req`. It is one-hot on the lowest-indexed set request line, or zero if no request is set, in every state.
- R9: `idle_full`=1 selects standard idle whatever the divisor code is. An `idle_req` issued while already idle is ignored and changes neither the period nor the wake timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | One-cycle idle command from the core |
| idle_full | input | 1 | 1 = standard idle at full rate |
| idle_div_sel | input | 2 | Divisor code for divided idle |
| irq_pending | input | 1 | An unmasked interrupt is pending |
| dma_req | input | DMA_LINES | Cycle-steal request lines |
| core_ce | output | 1 | Core instruction clock enable |
| aux_ce | output | 1 | Enable for the derived, slowed clocks |
| resume_pulse | output | 1 | One-cycle strobe on the first running cycle after idle |
| dma_grant | output | DMA_LINES | One-hot cycle-steal grant |

## Verification
The sharpest coincidence is an interrupt that arrives in the last cycle of a slowed period, in the same cycle as a DMA request. The bench drives both at the falling edge just before the period boundary. It then expects that, on the next cycle, `core_ce` returns and `resume_pulse` fires together with the correct one-hot grant, with no extra period added. Other cases show an interrupt raised early in a period waiting out the rest of that period, and an idle command during idle leaving the period length unchanged.

// File: rtl/sidle_pkg.sv
package sidle_pkg;
   typedef enum logic {
      ST_RUN  = 1'b0,
      ST_IDLE = 1'b1
   } sidle_state_e;

   // log2 of the period for a divisor code
   function automatic int period_log2(input int base_log2, input int code);
      return base_log2 + code;
   endfunction
endpackage

// File: rtl/sidle_divcnt.sv
module sidle_divcnt #(
   parameter int BASE_LOG2 = 4,
   parameter int CODE_W    = 2,
   localparam int NCODES   = 1 << CODE_W,
   localparam int CNT_W    = BASE_LOG2 + NCODES - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              full,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_tab [NCODES];
   logic [CNT_W-1:0] lim;

   for (genvar g = 0; g < NCODES; g++) begin : g_lim
      assign lim_tab[g] =
         CNT_W'((64'd1 << sidle_pkg::period_log2(BASE_LOG2, g)) - 64'd1);
   end

   assign lim  = lim_tab[code];
   assign tick = active && (full || (cnt == lim));

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (!active || tick) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sidle_fsm.sv
module sidle_fsm #(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_req,
   input  logic              idle_full,
   input  logic [CODE_W-1:0] idle_div_sel,
   input  logic              irq_pending,
   input  logic              tick,
   output logic              active,
   output logic              full_q,
   output logic [CODE_W-1:0] code_q,
   output logic              resume
);
   import sidle_pkg::*;

   sidle_state_e st;
   logic         wake;

   assign active = (st == ST_IDLE);
   assign wake   = active && irq_pending && tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_RUN;
         full_q <= 1'b0;
         code_q <= '0;
         resume <= 1'b0;
      end else begin
         resume <= wake;
         case (st)
            ST_RUN: if (idle_req) begin
               st     <= ST_IDLE;
               full_q <= idle_full;
               code_q <= idle_div_sel;
            end
            ST_IDLE: if (wake) st <= ST_RUN;
            default: st <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/sidle_dma_arb.sv
module sidle_dma_arb #(
   parameter int LINES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req,
   output logic [LINES-1:0] grant
);
   logic [LINES-1:0] pick;
   logic [LINES:0]   seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < LINES; i++) begin : g_pri
      assign pick[i]   = req[i] && !seen[i];
      assign seen[i+1] = seen[i] || req[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) grant <= '0;
      else        grant <= pick;
   end
endmodule

// File: rtl/slow_idle_ctrl.sv
module slow_idle_ctrl #(
   parameter int DMA_LINES = 3,
   parameter int BASE_LOG2 = 4,
   parameter int CODE_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idle_req,
   input  logic                 idle_full,
   input  logic [CODE_W-1:0]    idle_div_sel,
   input  logic                 irq_pending,
   input  logic [DMA_LINES-1:0] dma_req,
   output logic                 core_ce,
   output logic                 aux_ce,
   output logic                 resume_pulse,
   output logic [DMA_LINES-1:0] dma_grant
);
   if (DMA_LINES < 1) begin : g_bad_lines
      $error("DMA_LINES must be at least 1");
   end
   if (BASE_LOG2 < 1 || BASE_LOG2 + (1 << CODE_W) > 32) begin : g_bad_div
      $error("BASE_LOG2/CODE_W give an unsupported period range");
   end

   logic              active;
   logic              full_q;
   logic [CODE_W-1:0] code_q;
   logic              tick;

   sidle_fsm #(.CODE_W(CODE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_full(idle_full),
      .idle_div_sel(idle_div_sel), .irq_pending(irq_pending), .tick(tick),
      .active(active), .full_q(full_q), .code_q(code_q), .resume(resume_pulse)
   );

   sidle_divcnt #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .active(active), .full(full_q),
      .code(code_q), .tick(tick)
   );

   sidle_dma_arb #(.LINES(DMA_LINES)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(dma_req), .grant(dma_grant)
   );

   assign core_ce = !active;
   assign aux_ce  = !active || tick;
endmodule

// File: rtl/slow_idle_ctrl_chk.sv
module slow_idle_ctrl_chk #(
   parameter int DMA_LINES = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 idle_req,
   input logic                 irq_pending,
   input logic [DMA_LINES-1:0] dma_req,
   input logic                 core_ce,
   input logic                 aux_ce,
   input logic                 resume_pulse,
   input logic [DMA_LINES-1:0] dma_grant
);
   p_run_aux_r2: assert property (@(posedge clk) disable iff (!rst_n)
      core_ce |-> aux_ce);
   p_stop_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_ce) |-> $past(idle_req));
   p_resume_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resume_pulse |=> !resume_pulse);
   p_resume_first_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resume_pulse |-> (core_ce && !$past(core_ce)));
   p_rise_marked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_ce) |-> resume_pulse);
   p_irq_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ce && !idle_req) |=> core_ce);
   p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dma_grant));
   p_grant_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|dma_req) |=> (|dma_grant));
   p_grant_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req == '0) |=> (dma_grant == '0));
endmodule

bind slow_idle_ctrl slow_idle_ctrl_chk #(.DMA_LINES(DMA_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .irq_pending(irq_pending),
   .dma_req(dma_req), .core_ce(core_ce), .aux_ce(aux_ce),
   .resume_pulse(resume_pulse), .dma_grant(dma_grant)
);

// File: tb/test_slow_idle_ctrl.sv
`timescale 1ns/1ps
module test_slow_idle_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idle_req = 1'b0;
   logic       idle_full = 1'b0;
   logic [1:0] idle_div_sel = 2'b00;
   logic       irq_pending = 1'b0;
   logic [2:0] dma_req = 3'b000;
   logic       core_ce, aux_ce, resume_pulse;
   logic [2:0] dma_grant;
   int         n_checks = 0;
   int         n_errs = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   slow_idle_ctrl i_slow_idle_ctrl (
      .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_full(idle_full),
      .idle_div_sel(idle_div_sel), .irq_pending(irq_pending), .dma_req(dma_req),
      .core_ce(core_ce), .aux_ce(aux_ce), .resume_pulse(resume_pulse),
      .dma_grant(dma_grant)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Issue an idle command; returns at the falling edge of idle cycle 0.
   task automatic enter_idle(input logic full, input logic [1:0] code);
      @(negedge clk);
      idle_req = 1'b1; idle_full = full; idle_div_sel = code;
      @(negedge clk);
      idle_req = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "core_ce in reset", int'(core_ce), 1);
      chk("R1", "aux_ce in reset", int'(aux_ce), 1);
      chk("R1", "resume in reset", int'(resume_pulse), 0);
      chk("R1", "grant in reset", int'(dma_grant), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "core_ce after reset", int'(core_ce), 1);
      chk("R1", "resume after reset", int'(resume_pulse), 0);
   endtask

   // Divided idle: check the pulse pattern, raise irq in cycle k_irq, expect resume at n.
   task automatic t_divided(input logic [1:0] code, input int k_irq, input string req);
      int n = 16 << code;
      int bad_aux = 0, bad_core = 0;
      enter_idle(1'b0, code);
      for (int k = 0; k < n; k++) begin
         if (int'(aux_ce) != ((k == n - 1) ? 1 : 0)) bad_aux++;
         if (core_ce !== 1'b0) bad_core++;
         if (k == k_irq) irq_pending = 1'b1;
         @(negedge clk);
      end
      chk("R4", "aux_ce pattern mismatches", bad_aux, 0);
      chk("R2", "core_ce high while idle", bad_core, 0);
      chk(req, "core_ce at cycle n", int'(core_ce), 1);
      chk("R6", "resume at first run cycle", int'(resume_pulse), 1);
      irq_pending = 1'b0;
      @(negedge clk);
      chk("R6", "resume one cycle only", int'(resume_pulse), 0);
   endtask

   task automatic t_full;
      int bad = 0;
      enter_idle(1'b1, 2'b11);   // R9: code ignored in standard idle
      chk("R2", "core_ce stops after command", int'(core_ce), 0);
      for (int k = 0; k < 5; k++) begin
         if (aux_ce !== 1'b1 || core_ce !== 1'b0) bad++;
         @(negedge clk);
      end
      chk("R9", "full idle aux every cycle", bad, 0);
      irq_pending = 1'b1;
      @(negedge clk);
      chk("R3", "one-cycle wake core_ce", int'(core_ce), 1);
      chk("R6", "resume on full wake", int'(resume_pulse), 1);
      irq_pending = 1'b0;
      @(negedge clk);
      chk("R6", "resume cleared", int'(resume_pulse), 0);
   endtask

   task automatic t_ignore_cmd;
      int bad = 0;
      enter_idle(1'b0, 2'b00);
      for (int k = 0; k < 16; k++) begin
         if (int'(aux_ce) != ((k == 15) ? 1 : 0)) bad++;
         idle_req = (k == 2); idle_full = (k == 2); idle_div_sel = 2'b11;
         if (k == 4) irq_pending = 1'b1;
         @(negedge clk);
      end
      idle_req = 1'b0; idle_full = 1'b0;
      chk("R9", "idle command during idle changed period", bad, 0);
      chk("R9", "wake timing after ignored command", int'(core_ce), 1);
      irq_pending = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_irq_run;
      int bad = 0;
      irq_pending = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         if (core_ce !== 1'b1 || aux_ce !== 1'b1 || resume_pulse !== 1'b0) bad++;
      end
      irq_pending = 1'b0;
      chk("R7", "irq while running disturbed outputs", bad, 0);
   endtask

   task automatic t_dma_pattern(input logic [2:0] req, input logic [2:0] exp);
      @(negedge clk);
      dma_req = req;
      @(negedge clk);
      chk("R8", $sformatf("grant for req %b", req), int'(dma_grant), int'(exp));
   endtask

   task automatic t_dma;
      t_dma_pattern(3'b110, 3'b010);
      t_dma_pattern(3'b101, 3'b001);
      t_dma_pattern(3'b100, 3'b100);
      t_dma_pattern(3'b000, 3'b000);
      enter_idle(1'b0, 2'b10);
      dma_req = 3'b011;
      @(negedge clk);
      chk("R8", "grant while in divided idle", int'(dma_grant), 1);
      chk("R8", "core still idle", int'(core_ce), 0);
      dma_req = 3'b000;
      irq_pending = 1'b1;
      for (int k = 0; k < 64; k++) begin
         if (core_ce === 1'b1) break;
         @(negedge clk);
      end
      irq_pending = 1'b0;
      chk("R5", "wake from n=64 idle", int'(core_ce), 1);
      @(negedge clk);
   endtask

   // Interrupt and DMA request both land in the last cycle of a period.
   task automatic t_boundary;
      enter_idle(1'b0, 2'b00);
      repeat (15) @(negedge clk);
      chk("R4", "aux pulse at cycle 15", int'(aux_ce), 1);
      irq_pending = 1'b1; dma_req = 3'b100;
      @(negedge clk);
      chk("R5", "boundary wake no extra period", int'(core_ce), 1);
      chk("R6", "boundary resume", int'(resume_pulse), 1);
      chk("R8", "grant with resume", int'(dma_grant), 4);
      irq_pending = 1'b0; dma_req = 3'b000;
      @(negedge clk);
   endtask

   task automatic t_pending_at_entry;
      irq_pending = 1'b1;
      enter_idle(1'b0, 2'b01);
      repeat (31) @(negedge clk);
      chk("R5", "pending irq still idle at cycle 31", int'(core_ce), 0);
      @(negedge clk);
      chk("R5", "pending irq resumes at cycle 32", int'(core_ce), 1);
      irq_pending = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_irq_run();
      t_divided(2'b00, 3, "R5");
      t_divided(2'b01, 0, "R5");
      t_divided(2'b10, 63, "R5");
      t_divided(2'b11, 100, "R5");
      t_full();
      t_ignore_cmd();
      t_dma();
      t_boundary();
      t_pending_at_entry();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end
endmodule